// File: doc/BRIEF.md
# URL Content-Based Request Steering

This block watches the payload of arriving HTTP request packets, one byte per clock, and decides which server class should receive each packet. Bytes come in as a stream framed by a start-of-packet flag and an end-of-packet flag. While the bytes pass, two independent matchers look for fixed request substrings anywhere in the packet. The payload itself is not stored.

When the final byte of a packet has been accepted, the block presents a 2-bit destination code together with a one-cycle strobe. A request naming a script directory goes to the application server class. A request naming a JPEG picture goes to the image server class. Every other request goes to the default HTML server class. If both texts appear, the application class wins. Forwarding of the packet, TCP reassembly and header parsing are handled elsewhere.

Top module: `url_steer_top`

## Requirements
- R1: A byte is consumed only in a cycle with `in_valid` high; idle cycles inside a packet have no effect on the decision.
- R2: A packet whose bytes contain the text ".jpg" (and not "cgi-bin/") gets code 1 (image).
- R3: A packet whose bytes contain the text "cgi-bin/" gets code 2 (application).
- R4: When a packet contains both texts, in either order, the code is 2.
- R5: A packet containing neither text gets code 0 (HTML).
- R6: `dest_valid` is high for exactly the one cycle after the clock edge that accepts the end-of-packet byte, and low in every other cycle. `dest_code` holds the decision in that cycle. Code 3 is never produced.
- R7: Matching restarts correctly on overlapping partial matches: for example "..jpg", ".j.jpg", "ccgi-bin/" and "cgi-cgi-bin/" all match.
- R8: Match state is cleared at a start-of-packet byte and after an end-of-packet byte. A text split across two packets does not match.
- R9: After reset, `dest_valid` is 0 and `dest_code` is 0.
- R10: Matching is case-sensitive: ".JPG" and "CGI-BIN/" are not hits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Byte on `in_byte` is present this cycle |
| in_sop | input | 1 | Present byte is the first of a packet |
| in_eop | input | 1 | Present byte is the last of a packet |
| in_byte | input | 8 | Payload byte |
| dest_valid | output | 1 | One-cycle decision strobe |
| dest_code | output | 2 | 0 HTML, 1 image, 2 application |

## Verification
Each pattern is swept across every start position inside filler packets of fixed length. This shows that a hit is seen at the first byte, in the middle and at the last byte. Both patterns are placed together in both orders to separate the precedence rule from plain detection. Overlap strings, upper-case look-alikes and texts split over two packets tell a correct restarting matcher apart from one that drops partial matches, ignores case or leaks state between packets. Each packet is sent once with no gaps and once with an idle cycle after every byte, which confirms that gaps do not disturb the result.

// File: rtl/url_steer_pkg.sv
package url_steer_pkg;

    typedef enum logic [1:0] {
        DEST_HTML  = 2'd0,
        DEST_IMAGE = 2'd1,
        DEST_APP   = 2'd2
    } dest_e;

    localparam int BYTE_W = 8;

    localparam int IMG_LEN = 4;
    localparam logic [BYTE_W*IMG_LEN-1:0] IMG_TEXT = ".jpg";

    localparam int APP_LEN = 8;
    localparam logic [BYTE_W*APP_LEN-1:0] APP_TEXT = "cgi-bin/";

endpackage

// File: rtl/url_pat_matcher.sv
// Sliding-window matcher for one fixed text. It keeps the last
// PAT_LEN-1 bytes of the current packet and compares them, together
// with the arriving byte, against the whole pattern. This handles
// overlapping partial matches without any restart table.
module url_pat_matcher
    import url_steer_pkg::*;
#(
    parameter int PAT_LEN = 4,
    parameter logic [BYTE_W*PAT_LEN-1:0] PATTERN = ".jpg"
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_sop,
    input  logic              in_eop,
    input  logic [BYTE_W-1:0] in_byte,
    output logic              pkt_hit
);

    localparam int HIST_W = BYTE_W * (PAT_LEN - 1);
    localparam int FILL_W = $clog2(PAT_LEN);
    localparam logic [FILL_W-1:0] FILL_MAX = FILL_W'(PAT_LEN - 1);

    typedef struct packed {
        logic [HIST_W-1:0] hist;
        logic [FILL_W-1:0] fill;
        logic              hit;
    } mstate_t;

    mstate_t st_d, st_q;
    mstate_t base;
    logic    match_now;

    always_comb begin
        base = st_q;
        if (in_valid && in_sop) begin
            base = '0;
        end

        match_now = in_valid && (base.fill == FILL_MAX)
                    && ({base.hist, in_byte} == PATTERN);
        pkt_hit   = base.hit | match_now;

        st_d = st_q;
        if (in_valid) begin
            if (in_eop) begin
                st_d = '0;
            end else begin
                st_d.hist = {base.hist[HIST_W-BYTE_W-1:0], in_byte};
                st_d.fill = (base.fill == FILL_MAX) ? base.fill
                                                    : base.fill + 1'b1;
                st_d.hit  = pkt_hit;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R8: nothing carries over past the last byte of a packet
    p_eop_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_eop) |=> (st_q.fill == '0 && !st_q.hit));

    // R7: the window fill count never runs past the pattern length
    p_fill_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.fill <= FILL_MAX);

    // R1: an idle cycle leaves the window untouched
    p_idle_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(st_q));

endmodule

// File: rtl/url_dest_resolve.sv
// Applies the fixed precedence to the two hit flags and registers
// the one-cycle decision.
module url_dest_resolve
    import url_steer_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  in_valid,
    input  logic  in_eop,
    input  logic  img_hit,
    input  logic  app_hit,
    output logic  dest_valid,
    output dest_e dest_code
);

    typedef struct packed {
        logic  valid;
        dest_e code;
    } dout_t;

    dout_t out_d, out_q;

    always_comb begin
        out_d       = out_q;
        out_d.valid = 1'b0;
        if (in_valid && in_eop) begin
            out_d.valid = 1'b1;
            if (app_hit) begin
                out_d.code = DEST_APP;
            end else if (img_hit) begin
                out_d.code = DEST_IMAGE;
            end else begin
                out_d.code = DEST_HTML;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '{valid: 1'b0, code: DEST_HTML};
        end else begin
            out_q <= out_d;
        end
    end

    assign dest_valid = out_q.valid;
    assign dest_code  = out_q.code;

    // R4: an application hit always decides the code
    p_app_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
        dest_valid |-> ((dest_code == DEST_APP) == $past(app_hit)));

    // R2: image code only with an image hit and no application hit
    p_img_code_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (dest_valid && dest_code == DEST_IMAGE) |-> $past(img_hit && !app_hit));

endmodule

// File: rtl/url_steer_top.sv
module url_steer_top
    import url_steer_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_valid,
    input  logic       in_sop,
    input  logic       in_eop,
    input  logic [7:0] in_byte,
    output logic       dest_valid,
    output logic [1:0] dest_code
);

    logic  img_hit;
    logic  app_hit;
    dest_e code_w;

    url_pat_matcher #(
        .PAT_LEN (IMG_LEN),
        .PATTERN (IMG_TEXT)
    ) img_match_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_sop   (in_sop),
        .in_eop   (in_eop),
        .in_byte  (in_byte),
        .pkt_hit  (img_hit)
    );

    url_pat_matcher #(
        .PAT_LEN (APP_LEN),
        .PATTERN (APP_TEXT)
    ) app_match_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_sop   (in_sop),
        .in_eop   (in_eop),
        .in_byte  (in_byte),
        .pkt_hit  (app_hit)
    );

    url_dest_resolve resolve_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_eop     (in_eop),
        .img_hit    (img_hit),
        .app_hit    (app_hit),
        .dest_valid (dest_valid),
        .dest_code  (code_w)
    );

    assign dest_code = code_w;

    // R6: a strobe follows exactly an accepted end-of-packet byte
    p_strobe_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
        dest_valid |-> $past(in_valid && in_eop));

    p_strobe_due_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_eop) |=> dest_valid);

    // R6: the unused code value never appears
    p_code_legal_r6: assert property (@(posedge clk) disable iff (!rst_n)
        dest_valid |-> (dest_code != 2'd3));

endmodule

// File: tb/url_steer_top_tb_top.sv
module url_steer_top_tb_top;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       in_valid, in_sop, in_eop;
    logic [7:0] in_byte;
    logic       dest_valid;
    logic [1:0] dest_code;

    int checks   = 0;
    int failures = 0;
    int cycles   = 0;

    always #2 clk = ~clk;

    url_steer_top dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_sop     (in_sop),
        .in_eop     (in_eop),
        .in_byte    (in_byte),
        .dest_valid (dest_valid),
        .dest_code  (dest_code)
    );

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            failures++;
            $display("FAIL watchdog: actual=%0d cycles expected<=150000", cycles);
            summary();
            $finish;
        end
    end

    task automatic check_eq(int act, int exp, string req, string what);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int has_text(string s, string p);
        for (int i = 0; i + p.len() <= s.len(); i++) begin
            if (s.substr(i, i + p.len() - 1) == p) return 1;
        end
        return 0;
    endfunction

    // Codes per R2, R3, R4, R5: 2 application, 1 image, 0 HTML
    function automatic int expect_code(string s);
        if (has_text(s, "cgi-bin/") != 0) return 2;
        if (has_text(s, ".jpg") != 0) return 1;
        return 0;
    endfunction

    task automatic idle();
        in_valid = 1'b0;
        in_sop   = 1'b0;
        in_eop   = 1'b0;
        in_byte  = 8'h00;
    endtask

    task automatic send_pkt(string s, int gap, string req);
        int n = s.len();
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_sop   = (i == 0);
            in_eop   = (i == n - 1);
            in_byte  = s[i];
            if (gap != 0 && i != n - 1) begin
                @(negedge clk);
                idle();
                check_eq(int'(dest_valid), 0, "R6", "strobe inside packet");
            end
        end
        @(negedge clk);
        idle();
        check_eq(int'(dest_valid), 1, "R6", "strobe after eop");
        check_eq(int'(dest_code), expect_code(s), req, s);
        @(negedge clk);
        check_eq(int'(dest_valid), 0, "R6", "strobe one cycle");
    endtask

    initial begin
        string filler = "abcdefghklmnoqrstuvwxyz";
        string s;
        idle();
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        check_eq(int'(dest_valid), 0, "R9", "reset valid");
        check_eq(int'(dest_code), 0, "R9", "reset code");
        rst_n = 1'b1;
        @(negedge clk);
        check_eq(int'(dest_valid), 0, "R9", "valid after reset");

        // R2 / R3: each pattern at every position of a 16-byte packet
        for (int gap = 0; gap < 2; gap++) begin
            for (int pos = 0; pos <= 12; pos++) begin
                s = {filler.substr(0, 15 - 0)};
                s = {(pos > 0) ? filler.substr(0, pos - 1) : "", ".jpg",
                     filler.substr(pos, 11)};
                send_pkt(s, gap, (gap != 0) ? "R1" : "R2");
            end
            for (int pos = 0; pos <= 8; pos++) begin
                s = {(pos > 0) ? filler.substr(0, pos - 1) : "", "cgi-bin/",
                     filler.substr(pos, 7)};
                send_pkt(s, gap, (gap != 0) ? "R1" : "R3");
            end
        end

        // R4: both patterns, both orders
        send_pkt("GET /x.jpg?cgi-bin/run", 0, "R4");
        send_pkt("GET /cgi-bin/a.jpg", 0, "R4");
        send_pkt("cgi-bin/.jpg", 1, "R4");

        // R5: neither pattern
        send_pkt("GET /index.html HTTP/1.1", 0, "R5");
        send_pkt("q", 0, "R5");
        send_pkt(".jp", 0, "R5");
        send_pkt("cgi-bin", 0, "R5");
        send_pkt(".jpgx", 0, "R2");

        // R7: overlapping partial matches
        send_pkt("..jpg", 0, "R7");
        send_pkt(".j.jpg", 0, "R7");
        send_pkt(".jp.jpg", 0, "R7");
        send_pkt("ccgi-bin/", 0, "R7");
        send_pkt("cgi-cgi-bin/", 0, "R7");
        send_pkt("cgi-bicgi-bin/", 0, "R7");

        // R8: a pattern split over two packets must not match
        send_pkt("zz.j", 0, "R8");
        send_pkt("pg zz", 0, "R8");
        send_pkt("/cgi-b", 0, "R8");
        send_pkt("in/ok", 0, "R8");
        send_pkt("abc.jp", 1, "R8");
        send_pkt("g", 0, "R8");

        // R10: case sensitivity
        send_pkt("GET /A.JPG", 0, "R10");
        send_pkt("GET /CGI-BIN/x", 0, "R10");

        // R1: long idle stretch between packets then a hit
        repeat (10) @(negedge clk);
        check_eq(int'(dest_valid), 0, "R1", "idle no strobe");
        send_pkt("x.jpg", 1, "R1");

        summary();
        $finish;
    end

endmodule